// File: doc/BRIEF.md
# BCD Time-of-Day Alarm Comparator

This block holds a set of alarm fields and compares them against the running time of day, kept in BCD in 24-hour form, once per second. Seconds, minutes and hours alarms are always built. Day-of-month and month alarms are build-time options that stretch the alarm reach from a day to a month or to a year. The month alarm exists only when the day alarm exists. When every field that is not a wildcard equals the current time at an update strobe, the block raises a single-cycle match pulse.

A field whose two most significant bits are both 1 (for example 0xFF) is a wildcard and matches any time value. The day field compares only its low six bits. A day or month alarm of zero means "unspecified" and also matches anything. The time counters, interrupt flag logic and bus decoding sit outside this block. The register port is plain control, not a stream. A write lands in the clock edge where `wr_en` is high. `rd_data` is combinational from `rd_addr`. Neither direction has back-pressure.

Field addresses: 0 seconds, 1 minutes, 2 hours, 3 day of month, 4 month. Every other address is unmapped.

Top module: `alarm_match_unit`

## Requirements
- R1: After reset every alarm field reads 0x00 and `alarm_pulse` is low. So the reset alarm matches 00:00:00 on any day and any month, because zero day and month are unspecified.
- R2: `alarm_pulse` is high in the cycle after a cycle with `upd_stb` high, and only when every non-wildcard field equals the time inputs sampled in that strobe cycle.
- R3: `alarm_pulse` is never high in a cycle that does not follow a strobe. A write by itself never causes a pulse. A write in the strobe cycle takes effect only from the next strobe, because that strobe compares the old value.
- R4: A field whose bits [7:6] are both 1 is a wildcard that matches any value of its time input.
- R5: The day comparison uses only bits [5:0] of both the alarm and the current day. Bits [7:6] of the day alarm matter only for the wildcard code.
- R6: A day alarm whose bits [5:0] are zero, or a month alarm equal to 0x00, is unspecified and matches any value.
- R7: Reading address 0, 1, 2 or 4 returns the byte last written there. Reading address 3 returns the day alarm with bits [7:6] cleared.
- R8: When the day option is off (`HAS_DAY=0`), the day and month fields read 0x00, writes to them are ignored, and day and month take no part in the match. The month field also exists only when `HAS_MONTH=1`.
- R9: Writes to unmapped addresses (5 to 7) change no field, and reads of them return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_stb | input | 1 | Once-per-second strobe; the time inputs are valid in this cycle |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, BCD 24-hour |
| cur_day | input | 8 | Current day of month, BCD |
| cur_mon | input | 8 | Current month, BCD |
| wr_en | input | 1 | Write strobe for the alarm fields |
| wr_addr | input | 3 | Field address for a write |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Field address for readback |
| rd_data | output | 8 | Readback data, combinational |
| alarm_pulse | output | 1 | Single-cycle match pulse, one cycle after the strobe |

## Verification
A corrupted alarm field shows up at the ports in two ways. At the next update strobe it gives a missing or extra pulse one cycle later. It also reads back wrong on the combinational read port at once. A broken wildcard or zero-as-unspecified decode is seen only when the bench drives a time that differs from the stored field, so the bench sweeps times that disagree with each wildcard field. A pulse register that does not follow the strobe appears as a pulse on a cycle with no strobe before it, and the bench checks this on every idle cycle.

// File: rtl/alarm_cmp_pkg.sv
package alarm_cmp_pkg;
  localparam int NUM_FLD  = 5;
  localparam int IDX_SEC  = 0;
  localparam int IDX_MIN  = 1;
  localparam int IDX_HOUR = 2;
  localparam int IDX_DAY  = 3;
  localparam int IDX_MON  = 4;
  // the two top bits both set mark a wildcard field
  localparam logic [1:0] WILD_TOP = 2'b11;
  // day compares the low bits only
  localparam int DAY_LOW_W = 6;
endpackage

// File: rtl/alarm_field_reg.sv
module alarm_field_reg #(
  parameter int W       = 8,
  parameter int AW      = 3,
  parameter int ADDR    = 0,
  parameter bit PRESENT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  output logic [W-1:0]  q
);
  generate
    if (PRESENT) begin : g_store
      logic sel;
      assign sel = wr_en && (wr_addr == AW'(ADDR));

      always_ff @(posedge clk) begin
        if (!rst_n)   q <= '0;
        else if (sel) q <= wr_data;
      end

      // R7
      load_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel |=> (q == $past(wr_data)));
      // R9
      hold_without_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> $stable(q));
    end else begin : g_absent
      logic unused_ok;
      assign unused_ok = ^{clk, rst_n, wr_en, wr_addr, wr_data};
      assign q = '0;
    end
  endgenerate
endmodule

// File: rtl/alarm_field_cmp.sv
module alarm_field_cmp #(
  parameter int W         = 8,
  parameter bit PRESENT   = 1'b1,
  parameter bit LOW_ONLY  = 1'b0,
  parameter bit ZERO_WILD = 1'b0
) (
  input  logic [W-1:0] alarm,
  input  logic [W-1:0] cur,
  output logic         hit
);
  import alarm_cmp_pkg::*;
  localparam int       CMP_W = LOW_ONLY ? DAY_LOW_W : W;
  localparam logic [W-1:0] MASK = {{(W-CMP_W){1'b0}}, {CMP_W{1'b1}}};

  generate
    if (PRESENT) begin : g_cmp
      logic [W-1:0] a_m, c_m;
      logic         wild, unspec;
      always_comb begin
        a_m    = alarm & MASK;
        c_m    = cur & MASK;
        wild   = (alarm[W-1 -: 2] == WILD_TOP);
        unspec = ZERO_WILD && (a_m == '0);
        hit    = wild || unspec || (a_m == c_m);
      end
    end else begin : g_off
      logic unused_ok;
      assign unused_ok = ^{alarm, cur};
      assign hit = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/alarm_readback.sv
module alarm_readback #(
  parameter int W  = 8,
  parameter int AW = 3,
  parameter int NF = 5
) (
  input  logic [NF-1:0][W-1:0] fld,
  input  logic [AW-1:0]        rd_addr,
  output logic [W-1:0]         rd_data
);
  import alarm_cmp_pkg::*;
  localparam logic [W-1:0] DAY_MASK = {{(W-DAY_LOW_W){1'b0}}, {DAY_LOW_W{1'b1}}};

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NF; i++) begin
      if (rd_addr == AW'(i))
        rd_data = (i == IDX_DAY) ? (fld[i] & DAY_MASK) : fld[i];
    end
  end
endmodule

// File: rtl/alarm_match_unit.sv
module alarm_match_unit #(
  parameter int FIELD_W   = 8,
  parameter int ADDR_W    = 3,
  parameter bit HAS_DAY   = 1'b1,
  parameter bit HAS_MONTH = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               upd_stb,
  input  logic [FIELD_W-1:0] cur_sec,
  input  logic [FIELD_W-1:0] cur_min,
  input  logic [FIELD_W-1:0] cur_hour,
  input  logic [FIELD_W-1:0] cur_day,
  input  logic [FIELD_W-1:0] cur_mon,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [FIELD_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [FIELD_W-1:0] rd_data,
  output logic               alarm_pulse
);
  import alarm_cmp_pkg::*;
  localparam int NF = NUM_FLD;

  logic [NF-1:0][FIELD_W-1:0] alarm_q;
  logic [NF-1:0][FIELD_W-1:0] cur_v;
  logic [NF-1:0]              hit;
  logic                       all_hit;

  assign cur_v[IDX_SEC]  = cur_sec;
  assign cur_v[IDX_MIN]  = cur_min;
  assign cur_v[IDX_HOUR] = cur_hour;
  assign cur_v[IDX_DAY]  = cur_day;
  assign cur_v[IDX_MON]  = cur_mon;

  generate
    for (genvar i = 0; i < NF; i++) begin : g_fld
      localparam bit PRES = (i < IDX_DAY) ||
                            (i == IDX_DAY && HAS_DAY) ||
                            (i == IDX_MON && HAS_DAY && HAS_MONTH);

      alarm_field_reg #(
        .W(FIELD_W), .AW(ADDR_W), .ADDR(i), .PRESENT(PRES)
      ) u_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .q(alarm_q[i])
      );

      alarm_field_cmp #(
        .W(FIELD_W), .PRESENT(PRES),
        .LOW_ONLY(i == IDX_DAY), .ZERO_WILD(i >= IDX_DAY)
      ) u_cmp (
        .alarm(alarm_q[i]), .cur(cur_v[i]), .hit(hit[i])
      );

      // R4
      wildcard_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_q[i][FIELD_W-1 -: 2] == WILD_TOP) |-> hit[i]);
    end
  endgenerate

  alarm_readback #(.W(FIELD_W), .AW(ADDR_W), .NF(NF)) u_rb (
    .fld(alarm_q), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  assign all_hit = &hit;

  always_ff @(posedge clk) begin
    if (!rst_n) alarm_pulse <= 1'b0;
    else        alarm_pulse <= upd_stb && all_hit;
  end

  // R3
  pulse_needs_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_pulse |-> $past(upd_stb));
  // R2
  match_gives_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_stb && all_hit) |=> alarm_pulse);
  // R2
  miss_gives_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_stb && !all_hit) |=> !alarm_pulse);
  // R7
  day_top_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == ADDR_W'(IDX_DAY)) |-> (rd_data[FIELD_W-1 -: 2] == 2'b00));
endmodule

// File: tb/alarm_match_unit_tb.sv
`timescale 1ns/1ps
module alarm_match_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       upd_stb = 1'b0;
  logic [7:0] cur_sec = 8'h00, cur_min = 8'h00, cur_hour = 8'h00;
  logic [7:0] cur_day = 8'h01, cur_mon = 8'h01;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = 3'd0, rd_addr = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data, rd_short;
  logic       alarm_pulse, pulse_short;

  int checks = 0;
  int errors = 0;
  logic [7:0] mdl [5];
  bit   exp_q[$];
  bit   exp_s[$];
  string tag_q[$];
  logic stb_d = 1'b0;

  always #2.5 clk = ~clk;

  alarm_match_unit u_dut (
    .clk(clk), .rst_n(rst_n), .upd_stb(upd_stb),
    .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
    .cur_day(cur_day), .cur_mon(cur_mon),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .alarm_pulse(alarm_pulse)
  );

  alarm_match_unit #(.HAS_DAY(1'b0), .HAS_MONTH(1'b0)) u_short (
    .clk(clk), .rst_n(rst_n), .upd_stb(upd_stb),
    .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
    .cur_day(cur_day), .cur_mon(cur_mon),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_short), .alarm_pulse(pulse_short)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit wild(input logic [7:0] v);
    return v[7:6] == 2'b11;
  endfunction

  function automatic bit exp_match(input bit full, input logic [7:0] s, m, h, d, mo);
    bit ok;
    ok = (wild(mdl[0]) || mdl[0] == s) && (wild(mdl[1]) || mdl[1] == m) &&
         (wild(mdl[2]) || mdl[2] == h);
    if (full) begin
      ok = ok && (wild(mdl[3]) || mdl[3][5:0] == 6'd0 || mdl[3][5:0] == d[5:0]);
      ok = ok && (wild(mdl[4]) || mdl[4] == 8'h00 || mdl[4] == mo);
    end
    return ok;
  endfunction

  // scoreboard monitor
  always @(posedge clk) stb_d <= upd_stb;

  always @(negedge clk) begin
    if (rst_n) begin
      if (stb_d) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 scoreboard empty", 0, 1);
        end else begin
          bit e, es;
          string t;
          e = exp_q.pop_front(); es = exp_s.pop_front(); t = tag_q.pop_front();
          chk(alarm_pulse == e, t, alarm_pulse, e);
          chk(pulse_short == es, {t, " R8 short"}, pulse_short, es);
        end
      end else begin
        chk(!alarm_pulse && !pulse_short, "R3 pulse without strobe",
            {alarm_pulse, pulse_short}, 0);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a < 3'd5) mdl[a] = d;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [7:0] e, input logic [7:0] es,
                        input string tag);
    @(negedge clk);
    rd_addr = a;
    #1;
    chk(rd_data == e, tag, rd_data, e);
    chk(rd_short == es, {tag, " R8 short"}, rd_short, es);
  endtask

  // strobe with optional write in the same cycle (write applies after compare)
  task automatic tick(input logic [7:0] s, m, h, d, mo, input string tag,
                      input bit do_wr = 1'b0, input logic [2:0] wa = 3'd0,
                      input logic [7:0] wd = 8'h00);
    @(negedge clk);
    cur_sec = s; cur_min = m; cur_hour = h; cur_day = d; cur_mon = mo;
    upd_stb = 1'b1;
    exp_q.push_back(exp_match(1'b1, s, m, h, d, mo));
    exp_s.push_back(exp_match(1'b0, s, m, h, d, mo));
    tag_q.push_back(tag);
    if (do_wr) begin
      wr_en = 1'b1; wr_addr = wa; wr_data = wd;
    end
    @(negedge clk);
    upd_stb = 1'b0;
    if (do_wr) begin
      wr_en = 1'b0;
      if (wa < 3'd5) mdl[wa] = wd;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 5; i++) mdl[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int i = 0; i < 5; i++) rd_chk(3'(i), 8'h00, 8'h00, "R1 reset readback");
    chk(!alarm_pulse, "R1 reset pulse", alarm_pulse, 0);
    tick(8'h00, 8'h00, 8'h00, 8'h15, 8'h07, "R1 midnight reset alarm");
    tick(8'h01, 8'h00, 8'h00, 8'h15, 8'h07, "R1 reset alarm miss");

    // R7 programming and readback
    wr(3'd0, 8'h30); wr(3'd1, 8'h45); wr(3'd2, 8'h23); wr(3'd3, 8'h31); wr(3'd4, 8'h12);
    rd_chk(3'd0, 8'h30, 8'h30, "R7 sec readback");
    rd_chk(3'd1, 8'h45, 8'h45, "R7 min readback");
    rd_chk(3'd2, 8'h23, 8'h23, "R7 hour readback");
    rd_chk(3'd3, 8'h31, 8'h00, "R7 day readback");
    rd_chk(3'd4, 8'h12, 8'h00, "R7 month readback");

    // R2 exact matches and misses on each field
    tick(8'h30, 8'h45, 8'h23, 8'h31, 8'h12, "R2 full match");
    tick(8'h31, 8'h45, 8'h23, 8'h31, 8'h12, "R2 sec miss");
    tick(8'h30, 8'h44, 8'h23, 8'h31, 8'h12, "R2 min miss");
    tick(8'h30, 8'h45, 8'h22, 8'h31, 8'h12, "R2 hour miss");
    tick(8'h30, 8'h45, 8'h23, 8'h30, 8'h12, "R2 day miss R8 short hit");
    tick(8'h30, 8'h45, 8'h23, 8'h31, 8'h11, "R2 month miss");

    // R4 wildcards
    wr(3'd0, 8'hFF);
    tick(8'h59, 8'h45, 8'h23, 8'h31, 8'h12, "R4 sec wildcard FF");
    wr(3'd0, 8'hC3);
    tick(8'h07, 8'h45, 8'h23, 8'h31, 8'h12, "R4 sec wildcard C3");
    wr(3'd1, 8'hFF); wr(3'd2, 8'hFF); wr(3'd4, 8'hFF);
    tick(8'h12, 8'h34, 8'h05, 8'h31, 8'h03, "R4 many wildcards");
    wr(3'd3, 8'hFF);
    rd_chk(3'd3, 8'h3F, 8'h00, "R7 day wildcard readback");
    tick(8'h12, 8'h34, 8'h05, 8'h09, 8'h03, "R4 day wildcard");

    // R5 day compares low six bits
    wr(3'd3, 8'h45);
    rd_chk(3'd3, 8'h05, 8'h00, "R7 R5 day readback masked");
    tick(8'h00, 8'h00, 8'h00, 8'h05, 8'h01, "R5 day low bits match");
    tick(8'h00, 8'h00, 8'h00, 8'h15, 8'h01, "R5 day low bits miss");

    // R6 zero day / month unspecified
    wr(3'd4, 8'h00); wr(3'd3, 8'h40);
    rd_chk(3'd3, 8'h00, 8'h00, "R6 R7 day 40 readback");
    tick(8'h00, 8'h00, 8'h00, 8'h17, 8'h03, "R6 zero day and month");
    wr(3'd4, 8'h06);
    tick(8'h00, 8'h00, 8'h00, 8'h17, 8'h03, "R6 month 06 miss");
    wr(3'd4, 8'h00);

    // R3 writes alone never pulse; write in strobe cycle uses old value
    wr(3'd0, 8'h20); wr(3'd1, 8'h10); wr(3'd2, 8'h08);
    repeat (5) @(negedge clk);
    tick(8'h10, 8'h10, 8'h08, 8'h01, 8'h01, "R3 same-cycle write old value", 1'b1, 3'd0, 8'h10);
    rd_chk(3'd0, 8'h10, 8'h10, "R3 write in strobe cycle landed");
    tick(8'h10, 8'h10, 8'h08, 8'h01, 8'h01, "R3 new value next strobe");
    repeat (3) @(negedge clk);

    // R9 unmapped addresses
    wr(3'd5, 8'h12); wr(3'd7, 8'h34);
    rd_chk(3'd5, 8'h00, 8'h00, "R9 unmapped read 5");
    rd_chk(3'd7, 8'h00, 8'h00, "R9 unmapped read 7");
    rd_chk(3'd0, 8'h10, 8'h10, "R9 sec unchanged");
    rd_chk(3'd2, 8'h08, 8'h08, "R9 hour unchanged");

    // R8 absent day/month in short variant
    wr(3'd3, 8'h12); wr(3'd4, 8'h05);
    rd_chk(3'd3, 8'h12, 8'h00, "R8 day write ignored when absent");
    rd_chk(3'd4, 8'h05, 8'h00, "R8 month write ignored when absent");
    tick(8'h10, 8'h10, 8'h08, 8'h28, 8'h09, "R8 full miss short hit");
    tick(8'h10, 8'h10, 8'h08, 8'h12, 8'h05, "R8 both hit");

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule